// File: doc/BRIEF.md
# Transmit Descriptor Engine

This block is the transmit half of a descriptor-driven Ethernet DMA. Software builds a list of four-word descriptors in memory. Each descriptor names a data buffer, gives its length, and carries control flags. The engine fetches the descriptors one word at a time over a simple read port with one cycle of latency. For every descriptor that software has handed over, it streams the buffer out as bytes on a valid/ready byte interface. Each byte carries first-of-frame and last-of-frame markers and a CRC-suppress sideband flag. When a buffer is done, the engine writes word 0 back with the ownership bit cleared, which returns the descriptor to software.

When the engine meets a descriptor that software still owns, it raises a sticky buffer-unavailable status and parks on that same descriptor. A one-cycle poll-demand pulse makes it re-read the descriptor. A run input starts the walk from a programmed list base, and taking run low stops the engine at the next descriptor boundary. A flush pulse cuts the current buffer short and still returns the descriptor. A sticky completion interrupt is raised for any descriptor that asks for one, and a write-one-to-clear pulse per status bit clears it.

Top module: `tx_desc_engine`

## Requirements
- R1: A descriptor is four 32-bit words at consecutive byte addresses D, D+4, D+8 and D+12. Word 0 is control: bit 31 owned-by-engine, bit 30 interrupt-on-completion, bit 29 last buffer of frame, bit 28 first buffer of frame, bit 27 suppress CRC, bit 21 end of list, bit 20 follow pointer. Word 1 bits [12:0] hold the byte length, word 2 the word-aligned buffer address, and word 3 the next-descriptor address. No byte is sent from a descriptor whose bit 31 reads 0.
- R2: The buffer is sent as exactly length bytes, in ascending address order and little-endian within each 32-bit word, one byte per cycle in which both tx_valid_o and tx_ready_i are high. While tx_ready_i is low, tx_valid_o and tx_data_o stay stable.
- R3: tx_first_o is high only on the first byte of a descriptor that has bit 28 set. tx_last_o is high only on the final byte of a descriptor that has bit 29 set. tx_nocrc_o equals bit 27 on every byte.
- R4: After its buffer ends, the descriptor's word 0 is written back at address D with bit 31 cleared and all other bits unchanged. Words 1 to 3 are never written.
- R5: Fetching a word 0 with bit 31 clear sets stat_tbu_o, which stays set until cleared. The engine then suspends (suspended_o high) and keeps the same descriptor address.
- R6: While suspended, the engine issues no memory read until poll_i is pulsed. After the pulse it re-reads the descriptor at the same address.
- R7: The next descriptor address is word 3 when bit 20 is set. Otherwise it is base_i when bit 21 is set, and otherwise D+16.
- R8: Completing a descriptor with bit 30 set sets irq_o, which stays high until stat_clr_i[0] is pulsed. stat_clr_i[1] clears stat_tbu_o.
- R9: When run_i rises from the stopped state, fetching starts at base_i. Dropping run_i lets the current descriptor finish, then the engine stops without fetching the next one. Dropping run_i while suspended also stops the engine.
- R10: A flush_i pulse while a buffer is being sent ends that buffer early: no further bytes are sent and no last marker is given. The descriptor is still returned as in R4.
- R11: A descriptor with length 0 sends no bytes but is still returned and can still raise its interrupt.
- R12: After reset the engine is stopped, with no valid byte, no memory access and both status bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Start/stop control for transmit fetching |
| flush_i | input | 1 | Pulse: abandon the rest of the current buffer |
| poll_i | input | 1 | Pulse: re-read the current descriptor when suspended |
| base_i | input | ADDR_W | Byte address of the first descriptor of the list |
| stat_clr_i | input | 2 | Write-one-to-clear: bit 0 interrupt, bit 1 buffer-unavailable |
| mem_rd_o | output | 1 | Memory read request; data returns the next cycle |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | ADDR_W | Byte address for read or write |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after mem_rd_o |
| tx_data_o | output | 8 | Transmit byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Sink accepts the byte |
| tx_first_o | output | 1 | Byte is the first of a frame |
| tx_last_o | output | 1 | Byte is the last of a frame |
| tx_nocrc_o | output | 1 | CRC append suppressed for this frame |
| irq_o | output | 1 | Sticky transmit-complete interrupt |
| stat_tbu_o | output | 1 | Sticky buffer-unavailable status |
| suspended_o | output | 1 | Engine parked on an unowned descriptor |

## Verification
The hard cases are the ones where the walk through the list can go wrong. A frame split over two chained buffers must carry one first and one last marker, so an engine that marks per descriptor instead of following the flags gets caught. A list without pointers must wrap to the base on the end-of-list flag, so an engine that steps by 16 or follows a stale pointer would send nothing on the re-poll. A suspended engine must stay silent until polled, so one that re-fetches on its own would leak bytes during the wait. Buffer lengths that are not a multiple of four, a zero length, throttled ready patterns, a mid-buffer flush and run dropped mid-frame expose off-by-one byte counts, lost ownership write-backs and engines that stop too early or too late.

// File: rtl/txd_pkg.sv
// Shared constants and state type for the transmit descriptor engine.
// Assumes 32-bit memory words and byte addressing.
package txd_pkg;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned DESC_STRIDE = 16;
    localparam int unsigned OWN_BIT     = 31;
    localparam int unsigned IC_BIT      = 30;
    localparam int unsigned LS_BIT      = 29;
    localparam int unsigned FS_BIT      = 28;
    localparam int unsigned NOCRC_BIT   = 27;
    localparam int unsigned RER_BIT     = 21;
    localparam int unsigned CHN_BIT     = 20;

    typedef enum logic [3:0] {
        ST_STOP, ST_DREQ, ST_DCAP, ST_BREQ, ST_BCAP,
        ST_BOUT, ST_WBACK, ST_NEXT, ST_SUSP
    } eng_state_t;
endpackage

// File: rtl/txd_lane.sv
// Buffer byte lane: holds one fetched buffer word and the remaining byte count,
// and presents one byte at a time. Assumes buffers start word aligned.
module txd_lane
    import txd_pkg::*;
#(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_start_i,
    input  logic [LEN_W-1:0] buf_len_i,
    input  logic             word_we_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic             beat_i,
    output logic [7:0]       byte_o,
    output logic             head_o,
    output logic             last_byte_o,
    output logic             word_end_o
);
    localparam int LANES  = WORD_W / 8;
    localparam int LANE_W = $clog2(LANES);

    logic [WORD_W-1:0] word_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LANE_W-1:0] lane_q;
    logic              head_q;
    logic [7:0]        lane_bytes [LANES];

    // Split the held word into byte lanes, lowest address in lane 0.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word_q[8*g +: 8];
    end

    assign byte_o      = lane_bytes[lane_q];
    assign head_o      = head_q;
    assign last_byte_o = (rem_q == LEN_W'(1));
    assign word_end_o  = (lane_q == LANE_W'(LANES - 1));

    // Track the held word, remaining bytes, current lane and first-byte flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            rem_q  <= '0;
            lane_q <= '0;
            head_q <= 1'b0;
        end else begin
            if (word_we_i) word_q <= word_i;
            if (buf_start_i) begin
                rem_q  <= buf_len_i;
                lane_q <= '0;
                head_q <= 1'b1;
            end else if (beat_i) begin
                rem_q  <= rem_q - LEN_W'(1);
                lane_q <= lane_q + LANE_W'(1);
                head_q <= 1'b0;
            end
        end
    end

    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_i |-> (rem_q != '0)) else $error("byte sent past buffer end");

    assert_head_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i && !buf_start_i) |=> !head_o) else $error("first flag repeated");
endmodule

// File: rtl/txd_status.sv
// Sticky status: transmit-complete interrupt and buffer-unavailable flag,
// each cleared by a write-one pulse; a set in the same cycle wins.
module txd_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done_i,
    input  logic       done_ic_i,
    input  logic       unavail_i,
    input  logic [1:0] clr_i,
    output logic       irq_o,
    output logic       tbu_o
);
    logic ti_q;
    logic tbu_q;

    // Set or clear the two sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ti_q  <= 1'b0;
            tbu_q <= 1'b0;
        end else begin
            if (done_i && done_ic_i) ti_q <= 1'b1;
            else if (clr_i[0])       ti_q <= 1'b0;
            if (unavail_i)           tbu_q <= 1'b1;
            else if (clr_i[1])       tbu_q <= 1'b0;
        end
    end

    assign irq_o = ti_q;
    assign tbu_o = tbu_q;

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ti_q && !clr_i[0]) |=> ti_q) else $error("interrupt dropped without clear");

    assert_tbu_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tbu_q && !clr_i[1]) |=> tbu_q) else $error("unavailable flag dropped without clear");
endmodule

// File: rtl/txd_ctrl.sv
// Descriptor walker: fetches the four descriptor words, drives buffer reads,
// paces byte output, writes ownership back and picks the next descriptor.
// Assumes memory read data is valid exactly one cycle after the request.
module txd_ctrl
    import txd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              flush_i,
    input  logic              poll_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic              tx_first_o,
    output logic              tx_last_o,
    output logic              tx_nocrc_o,
    output logic              buf_start_o,
    output logic [LEN_W-1:0]  buf_len_o,
    output logic              word_we_o,
    output logic              beat_o,
    input  logic              head_i,
    input  logic              last_byte_i,
    input  logic              word_end_i,
    output logic              done_o,
    output logic              done_ic_o,
    output logic              unavail_o,
    output logic              suspended_o
);
    eng_state_t        state_q;
    logic [ADDR_W-1:0] cur_q;
    logic [1:0]        widx_q;
    logic [WORD_W-1:0] w0_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] baddr_q;
    logic [ADDR_W-1:0] nxt_q;

    // Memory request decode per state.
    always_comb begin
        mem_rd_o   = (state_q == ST_DREQ) || (state_q == ST_BREQ);
        mem_wr_o   = (state_q == ST_WBACK);
        mem_wdata_o = w0_q & ~(WORD_W'(1) << OWN_BIT);
        unique case (state_q)
            ST_DREQ: mem_addr_o = cur_q + (ADDR_W'(widx_q) << 2);
            ST_BREQ: mem_addr_o = baddr_q;
            default: mem_addr_o = cur_q;
        endcase
    end

    assign tx_valid_o  = (state_q == ST_BOUT);
    assign beat_o      = tx_valid_o && tx_ready_i;
    assign tx_first_o  = tx_valid_o && w0_q[FS_BIT] && head_i;
    assign tx_last_o   = tx_valid_o && w0_q[LS_BIT] && last_byte_i;
    assign tx_nocrc_o  = tx_valid_o && w0_q[NOCRC_BIT];
    assign buf_start_o = (state_q == ST_DCAP) && (widx_q == 2'd3) && (len_q != '0);
    assign buf_len_o   = len_q;
    assign word_we_o   = (state_q == ST_BCAP);
    assign done_o      = (state_q == ST_WBACK);
    assign done_ic_o   = w0_q[IC_BIT];
    assign unavail_o   = (state_q == ST_DCAP) && (widx_q == 2'd0) && !mem_rdata_i[OWN_BIT];
    assign suspended_o = (state_q == ST_SUSP);

    // Main sequencer: descriptor fetch, buffer streaming, write-back, next pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            cur_q   <= '0;
            widx_q  <= '0;
            w0_q    <= '0;
            len_q   <= '0;
            baddr_q <= '0;
            nxt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_STOP: if (run_i) begin
                    cur_q   <= base_i;
                    widx_q  <= '0;
                    state_q <= ST_DREQ;
                end
                ST_DREQ: state_q <= ST_DCAP;
                ST_DCAP: begin
                    unique case (widx_q)
                        2'd0: begin
                            w0_q <= mem_rdata_i;
                            if (!mem_rdata_i[OWN_BIT]) state_q <= ST_SUSP;
                            else begin
                                widx_q  <= 2'd1;
                                state_q <= ST_DREQ;
                            end
                        end
                        2'd1: begin
                            len_q   <= mem_rdata_i[LEN_W-1:0];
                            widx_q  <= 2'd2;
                            state_q <= ST_DREQ;
                        end
                        2'd2: begin
                            baddr_q <= ADDR_W'(mem_rdata_i);
                            widx_q  <= 2'd3;
                            state_q <= ST_DREQ;
                        end
                        default: begin
                            nxt_q   <= ADDR_W'(mem_rdata_i);
                            state_q <= (len_q == '0) ? ST_WBACK : ST_BREQ;
                        end
                    endcase
                end
                ST_BREQ: state_q <= flush_i ? ST_WBACK : ST_BCAP;
                ST_BCAP: state_q <= flush_i ? ST_WBACK : ST_BOUT;
                ST_BOUT: begin
                    if (flush_i || (beat_o && last_byte_i)) state_q <= ST_WBACK;
                    else if (beat_o && word_end_i) begin
                        baddr_q <= baddr_q + ADDR_W'(WORD_W / 8);
                        state_q <= ST_BREQ;
                    end
                end
                ST_WBACK: state_q <= ST_NEXT;
                ST_NEXT: begin
                    if (w0_q[CHN_BIT])      cur_q <= nxt_q;
                    else if (w0_q[RER_BIT]) cur_q <= base_i;
                    else                    cur_q <= cur_q + ADDR_W'(DESC_STRIDE);
                    widx_q  <= '0;
                    state_q <= run_i ? ST_DREQ : ST_STOP;
                end
                ST_SUSP: begin
                    if (!run_i) state_q <= ST_STOP;
                    else if (poll_i) begin
                        widx_q  <= '0;
                        state_q <= ST_DREQ;
                    end
                end
                default: state_q <= ST_STOP;
            endcase
        end
    end

    assert_valid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i && !flush_i) |=> (tx_valid_o && $stable(mem_addr_o)))
        else $error("byte withdrawn under backpressure");

    assert_susp_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended_o && !poll_i) |=> !mem_rd_o) else $error("read while suspended");

    assert_send_owned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid_o) |-> w0_q[OWN_BIT]) else $error("unowned buffer sent");

    assert_rw_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o)) else $error("read and write together");
endmodule

// File: rtl/tx_desc_engine.sv
// Top of the transmit descriptor engine: connects the walker, the byte lane
// and the sticky status. Memory is an external single-port model.
module tx_desc_engine
    import txd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              flush_i,
    input  logic              poll_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        stat_clr_i,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    output logic [7:0]        tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic              tx_first_o,
    output logic              tx_last_o,
    output logic              tx_nocrc_o,
    output logic              irq_o,
    output logic              stat_tbu_o,
    output logic              suspended_o
);
    logic             buf_start;
    logic [LEN_W-1:0] buf_len;
    logic             word_we;
    logic             beat;
    logic             head;
    logic             last_byte;
    logic             word_end;
    logic             done;
    logic             done_ic;
    logic             unavail;

    txd_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .flush_i(flush_i), .poll_i(poll_i),
        .base_i(base_i), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_first_o(tx_first_o),
        .tx_last_o(tx_last_o), .tx_nocrc_o(tx_nocrc_o), .buf_start_o(buf_start),
        .buf_len_o(buf_len), .word_we_o(word_we), .beat_o(beat), .head_i(head),
        .last_byte_i(last_byte), .word_end_i(word_end), .done_o(done),
        .done_ic_o(done_ic), .unavail_o(unavail), .suspended_o(suspended_o)
    );

    txd_lane #(.LEN_W(LEN_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .buf_start_i(buf_start), .buf_len_i(buf_len),
        .word_we_i(word_we), .word_i(mem_rdata_i), .beat_i(beat), .byte_o(tx_data_o),
        .head_o(head), .last_byte_o(last_byte), .word_end_o(word_end)
    );

    txd_status u_status (
        .clk(clk), .rst_n(rst_n), .done_i(done), .done_ic_i(done_ic),
        .unavail_i(unavail), .clr_i(stat_clr_i), .irq_o(irq_o), .tbu_o(stat_tbu_o)
    );
endmodule

// File: tb/sim_tx_desc_engine.sv
`timescale 1ns/1ps
module sim_tx_desc_engine;
    localparam logic [31:0] F_OWN = 32'h8000_0000, F_IC = 32'h4000_0000;
    localparam logic [31:0] F_LS = 32'h2000_0000, F_FS = 32'h1000_0000;
    localparam logic [31:0] F_NC = 32'h0800_0000, F_RER = 32'h0020_0000;
    localparam logic [31:0] F_CHN = 32'h0010_0000;
    // Vector fields: [11:10] ready pattern, [9] interrupt request, [8] no-CRC, [7:0] length
    localparam logic [11:0] VEC [0:5] = '{12'h201, 12'h504, 12'hA05, 12'h00D, 12'h740, 12'h907};

    logic clk = 0, rst_n = 0, run = 0, flush = 0, poll = 0, tx_ready = 0;
    logic [31:0] base = 0;
    logic [1:0] stat_clr = 0;
    logic mem_rd, mem_wr, tx_valid, tx_first, tx_last, tx_nocrc, irq, tbu, susp;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0] tx_data;
    logic [31:0] mem [0:255];
    logic [1:0] rmode = 0;
    logic [31:0] cyc = 0;
    logic [7:0] lg_d [0:255], exp_b [0:255];
    logic lg_f [0:255], lg_l [0:255], lg_c [0:255];
    int lg_n = 0, exp_n = 0, checks = 0, errors = 0;

    always #4 clk = ~clk;

    tx_desc_engine u0 (
        .clk(clk), .rst_n(rst_n), .run_i(run), .flush_i(flush), .poll_i(poll),
        .base_i(base), .stat_clr_i(stat_clr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
        .tx_first_o(tx_first), .tx_last_o(tx_last), .tx_nocrc_o(tx_nocrc),
        .irq_o(irq), .stat_tbu_o(tbu), .suspended_o(susp)
    );

    // Memory model: read data one cycle after the request.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
        if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
    end

    // Set ready for the coming edge, then log the byte accepted at that edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        case (rmode)
            2'd0: tx_ready = 1'b1;
            2'd1: tx_ready = cyc[0];
            default: tx_ready = cyc[2] | cyc[0];
        endcase
        if (rst_n && tx_valid && tx_ready) begin
            if (lg_n < 256) begin
                lg_d[lg_n] = tx_data; lg_f[lg_n] = tx_first;
                lg_l[lg_n] = tx_last; lg_c[lg_n] = tx_nocrc;
            end
            lg_n = lg_n + 1;
        end
    end

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    task automatic chk(bit ok, string msg, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_desc(int a, logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, logic [31:0] w3);
        mem[a >> 2] = w0; mem[(a >> 2) + 1] = w1; mem[(a >> 2) + 2] = w2; mem[(a >> 2) + 3] = w3;
    endtask

    task automatic clear_log();
        lg_n = 0; exp_n = 0;
    endtask

    task automatic add_exp(int a, int n);
        for (int i = 0; i < n; i++) begin
            exp_b[exp_n] = pat(a + i);
            exp_n++;
        end
    endtask

    task automatic wait_susp(string msg);
        int t;
        t = 0;
        while (!susp && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(susp == 1'b1, msg, int'(susp), 1);
    endtask

    task automatic clr_status(logic [1:0] m);
        @(negedge clk) stat_clr = m;
        @(negedge clk) stat_clr = 2'b00;
    endtask

    task automatic do_poll();
        @(negedge clk) poll = 1'b1;
        @(negedge clk) poll = 1'b0;
    endtask

    task automatic verify_log(string tag, bit fs, bit ls, bit nc);
        int bad;
        chk(lg_n == exp_n, {tag, " byte count"}, lg_n, exp_n);
        bad = 0;
        for (int i = 0; i < exp_n && i < lg_n && i < 256; i++) begin
            if (lg_d[i] !== exp_b[i]) bad++;
            if (lg_f[i] !== (fs && i == 0)) bad++;
            if (lg_l[i] !== (ls && i == exp_n - 1)) bad++;
            if (lg_c[i] !== nc) bad++;
        end
        chk(bad == 0, {tag, " data and markers"}, bad, 0);
    endtask

    initial begin
        #1_200_000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int w = 0; w < 256; w++)
            mem[w] = (w < 128) ? 32'h0 : {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        tick(5);
        // R12: reset state
        chk(!tx_valid && !mem_rd && !mem_wr, "R12 idle outputs after reset", int'(tx_valid), 0);
        chk(!irq && !tbu && !susp, "R12 status clear after reset", int'({irq, tbu, susp}), 0);
        @(negedge clk) rst_n = 1'b1;
        tick(3);
        chk(!mem_rd && !susp, "R12 stopped while run low", int'(mem_rd), 0);

        // Table of single-buffer frames: R2 R3 R4 R5 R8 R9
        for (int k = 0; k < 6; k++) begin
            logic [11:0] v;
            v = VEC[k];
            run = 1'b0;
            tick(3);
            clr_status(2'b11);
            rmode = v[11:10];
            put_desc(32'h000, F_OWN | F_FS | F_LS | F_CHN | (v[9] ? F_IC : 32'h0) | (v[8] ? F_NC : 32'h0),
                     {24'h0, v[7:0]}, 32'h200, 32'h010);
            put_desc(32'h010, 0, 0, 0, 0);
            clear_log();
            add_exp(32'h200, int'(v[7:0]));
            base = 32'h0;
            run = 1'b1;
            wait_susp("R5 suspend after table frame");
            verify_log("R2 R3 table frame", 1'b1, 1'b1, v[8]);
            chk(irq == v[9], "R8 interrupt follows request bit", int'(irq), int'(v[9]));
            chk(mem[0][31] == 1'b0 && mem[0][30:0] == ({F_FS | F_LS | F_CHN | (v[9] ? F_IC : 32'h0) | (v[8] ? F_NC : 32'h0)} & 32'h7FFF_FFFF),
                "R4 word0 returned", int'(mem[0][31]), 0);
            chk(mem[1] == {24'h0, v[7:0]} && mem[2] == 32'h200, "R4 words 1-2 untouched", int'(mem[1]), int'(v[7:0]));
            chk(tbu == 1'b1, "R5 unavailable status set", int'(tbu), 1);
        end

        // Two chained buffers forming one frame: R1 R3 R7
        run = 1'b0; tick(3); clr_status(2'b11); rmode = 2'd2;
        put_desc(32'h000, F_OWN | F_FS | F_CHN, 32'd3, 32'h204, 32'h040);
        put_desc(32'h040, F_OWN | F_LS | F_IC | F_CHN, 32'd6, 32'h300, 32'h080);
        put_desc(32'h080, 0, 0, 0, 0);
        put_desc(32'h090, 0, 0, 0, 0);
        clear_log(); add_exp(32'h204, 3); add_exp(32'h300, 6);
        run = 1'b1;
        wait_susp("R7 chained walk reaches unowned");
        verify_log("R3 R7 two-buffer frame", 1'b1, 1'b1, 1'b0);
        chk(mem[0][31] == 1'b0 && mem[16][31] == 1'b0, "R4 both descriptors returned", int'(mem[16][31]), 0);
        chk(irq == 1'b1, "R8 irq from last buffer", int'(irq), 1);

        // Suspend and poll: R1 R6
        clr_status(2'b11);
        put_desc(32'h080, F_OWN | F_FS | F_LS | F_CHN, 32'd2, 32'h280, 32'h090);
        clear_log();
        tick(20);
        chk(lg_n == 0, "R6 no bytes while suspended", lg_n, 0);
        chk(susp == 1'b1 && tbu == 1'b0, "R6 still parked without poll", int'(susp), 1);
        add_exp(32'h280, 2);
        do_poll();
        wait_susp("R6 poll resumes then parks");
        verify_log("R6 R1 polled frame", 1'b1, 1'b1, 1'b0);
        chk(tbu == 1'b1, "R1 unowned descriptor not processed", int'(tbu), 1);

        // End-of-list wrap without pointers: R7
        run = 1'b0; tick(3); clr_status(2'b11); rmode = 2'd0;
        for (int a = 32'h100; a < 32'h140; a += 16) put_desc(a, 0, 0, 0, 0);
        put_desc(32'h100, F_OWN | F_FS | F_LS, 32'd1, 32'h210, 32'h000);
        put_desc(32'h110, F_OWN | F_FS | F_LS | F_RER, 32'd2, 32'h220, 32'h000);
        base = 32'h100;
        clear_log(); add_exp(32'h210, 1); add_exp(32'h220, 2);
        run = 1'b1;
        wait_susp("R7 wrap parks at base");
        chk(lg_n == 3, "R7 contiguous step sends both", lg_n, 3);
        mem[32'h100 >> 2] = F_OWN | F_FS | F_LS;
        clear_log(); add_exp(32'h210, 1);
        do_poll();
        wait_susp("R7 re-park after wrap");
        verify_log("R7 wrapped to base", 1'b1, 1'b1, 1'b0);

        // Zero length: R11
        run = 1'b0; tick(3); clr_status(2'b11); base = 32'h0;
        put_desc(32'h000, F_OWN | F_IC | F_FS | F_LS | F_CHN, 32'd0, 32'h200, 32'h010);
        put_desc(32'h010, 0, 0, 0, 0);
        clear_log();
        run = 1'b1;
        wait_susp("R11 zero length moves on");
        chk(lg_n == 0, "R11 no bytes for zero length", lg_n, 0);
        chk(mem[0][31] == 1'b0 && irq == 1'b1, "R11 returned with interrupt", int'(irq), 1);

        // Sticky bits and separate clears: R8 R5
        tick(10);
        chk(irq == 1'b1, "R8 interrupt stays set", int'(irq), 1);
        clr_status(2'b01);
        chk(irq == 1'b0 && tbu == 1'b1, "R8 clear bit0 only interrupt", int'({irq, tbu}), 1);
        clr_status(2'b10);
        chk(tbu == 1'b0, "R5 clear bit1 unavailable", int'(tbu), 0);

        // Flush mid-buffer: R10
        run = 1'b0; tick(3); clr_status(2'b11); rmode = 2'd2;
        put_desc(32'h000, F_OWN | F_FS | F_LS | F_CHN, 32'd64, 32'h200, 32'h010);
        clear_log();
        run = 1'b1;
        for (int t = 0; t < 2000 && lg_n < 3; t++) @(negedge clk);
        flush = 1'b1;
        @(negedge clk) flush = 1'b0;
        wait_susp("R10 flush then next descriptor");
        chk(lg_n >= 3 && lg_n < 64, "R10 buffer cut short", lg_n, 3);
        begin
            int nl;
            nl = 0;
            for (int i = 0; i < lg_n && i < 256; i++) if (lg_l[i]) nl++;
            chk(nl == 0, "R10 no last marker after flush", nl, 0);
        end
        chk(mem[0][31] == 1'b0, "R10 flushed descriptor returned", int'(mem[0][31]), 0);

        // Run dropped mid-frame: R9
        run = 1'b0; tick(3); clr_status(2'b11); rmode = 2'd1;
        put_desc(32'h000, F_OWN | F_FS | F_LS | F_CHN, 32'd64, 32'h200, 32'h010);
        clear_log(); add_exp(32'h200, 64);
        run = 1'b1;
        for (int t = 0; t < 2000 && lg_n < 2; t++) @(negedge clk);
        run = 1'b0;
        for (int t = 0; t < 2000 && lg_n < 64; t++) @(negedge clk);
        tick(10);
        verify_log("R9 frame finishes after stop", 1'b1, 1'b1, 1'b0);
        chk(susp == 1'b0 && tbu == 1'b0, "R9 stopped without next fetch", int'({susp, tbu}), 0);
        chk(mem[0][31] == 1'b0, "R9 descriptor returned before stop", int'(mem[0][31]), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule